// File: doc/BRIEF.md
# Dual-Lane Synchronous Frame Shifter

This block is the host-side serial engine for a three-wire programming link that runs at high voltage. One transaction moves one frame. A frame drives two output lanes, a data lane and an instruction lane, in lockstep against a single serial clock that the block generates itself. Each lane carries its own 8-bit payload inside an 11-bit padded frame. In the same frame the block shifts in a returned byte from the target's output lane. A one-cycle start request launches the frame. When the last serial clock period ends, a one-cycle done pulse presents the captured byte.

The serial clock idles low. Every high phase and every low phase lasts `HALF_CYC` system clock cycles. Driven bits change only on the falling serial edge, so each bit has a full half period of setup before the rising edge and a full half period of hold after it. The returned lane is passed through a synchronizer and sampled on the last system cycle of each high phase, well after the target's output has settled. The returned byte uses the first eight bit slots of the frame. The driven payload sits one slot later, behind a leading zero. Command meaning, sequencing of several frames and power control belong to the logic that drives `start`.

Top module: `hvs_frame_shifter`

## Requirements
- R1: While reset is held and in the cycle after it is released, `ser_clk`, `dat_lane`, `ins_lane`, `busy` and `done` are 0 and `rx_byte` is 0x00.
- R2: An accepted start produces exactly 11 rising edges of `ser_clk`. `ser_clk` is low whenever `busy` is low.
- R3: At the rising edges 1..11 of a frame, `dat_lane` shows one 0 bit, then `data_byte` MSB first (bit 7 at edge 2, bit 0 at edge 9), then two 0 bits. `dat_lane` is low while idle.
- R4: At the same rising edges, `ins_lane` shows the same layout built from `instr_byte`, independent of `data_byte`. `ins_lane` is low while idle.
- R5: Every low phase of `ser_clk` lasts exactly `HALF_CYC` system cycles, counted from the start-sampling edge for the first one. Every high phase also lasts exactly `HALF_CYC` cycles (default 6, that is 120 ns at 20 ns per cycle).
- R6: `dat_lane` and `ins_lane` never change while `ser_clk` is high. Each driven bit is stable for the whole high phase that follows its rising edge.
- R7: `rx_byte` takes the value of `ret_lane` as it stands after rising edges 1..8, with edge 1 giving bit 7. The values after edges 9..11 have no effect.
- R8: `done` is a one-cycle pulse in the first cycle after the 11th high phase ends. `rx_byte` is updated in that same cycle and holds until the next `done`.
- R9: `busy` rises in the cycle after an accepted start and falls in the cycle in which `done` is high.
- R10: A start request while `busy` is high is ignored: the running frame keeps its payloads and its edge count, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled when idle |
| data_byte | input | 8 | Payload for the data lane, captured at launch |
| instr_byte | input | 8 | Payload for the instruction lane, captured at launch |
| ret_lane | input | 1 | Target output lane, asynchronous to clk |
| ser_clk | output | 1 | Generated serial clock, idles low |
| dat_lane | output | 1 | Driven data lane |
| ins_lane | output | 1 | Driven instruction lane |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| rx_byte | output | 8 | Byte captured from the return lane |

## Verification
Random frames use unrelated data, instruction and return bytes. A lane swap, a shared payload register or a shift in the wrong direction therefore shows up as a mismatch on one lane only. The directed patterns cover the edges of the value range. All zeros and all ones check that the zero padding is there and sits in the right place. The pattern 0x80 against 0x01 and complementary nibbles such as 0xA5 against 0x5A catch an off-by-one in bit position, in either the driven or the returned byte. The return lane carries random values in the three slots after the byte, so sampling the wrong window shows up. One frame receives a second start with different payloads in the middle of the frame, which separates a block that ignores the request from one that restarts or chains frames.

// File: rtl/hvs_pkg.sv
package hvs_pkg;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_SHIFT = 1'b1
   } hvs_state_t;

   // counter width for a modulus n, never below one bit
   function automatic int unsigned hvs_cnt_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/hvs_phase_timer.sv
module hvs_phase_timer import hvs_pkg::*; #(
   parameter int unsigned HALF_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic ser_clk,
   output logic fall_tick
);

   localparam int unsigned CNT_W = hvs_cnt_w(HALF_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

   logic [CNT_W-1:0] cnt;
   logic             lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         lvl <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         lvl <= 1'b0;
      end else if (cnt == LAST) begin
         cnt <= '0;
         lvl <= ~lvl;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign ser_clk   = lvl;
   assign fall_tick = run && lvl && (cnt == LAST);

endmodule

// File: rtl/hvs_lane_tx.sv
module hvs_lane_tx #(
   parameter int unsigned PAY_W   = 8,
   parameter int unsigned LEAD_W  = 1,
   parameter int unsigned TRAIL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic [PAY_W-1:0] payload,
   output logic             lane_out
);

   localparam int unsigned FRAME_W = LEAD_W + PAY_W + TRAIL_W;

   logic [FRAME_W-1:0] frame_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
      end else if (load) begin
         frame_q <= {{LEAD_W{1'b0}}, payload, {TRAIL_W{1'b0}}};
      end else if (shift) begin
         frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
      end
   end

   assign lane_out = frame_q[FRAME_W-1];

endmodule

// File: rtl/hvs_ret_capture.sv
module hvs_ret_capture #(
   parameter int unsigned RET_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ret_in,
   input  logic             clr,
   input  logic             take,
   output logic [RET_W-1:0] word
);

   logic ret_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign ret_s = ret_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q[0] <= ret_in;
               for (int s = 1; s < int'(SYNC_STAGES); s++) begin
                  sync_q[s] <= sync_q[s-1];
               end
            end
         end
         assign ret_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= '0;
      end else if (clr) begin
         word <= '0;
      end else if (take) begin
         word <= {word[RET_W-2:0], ret_s};
      end
   end

endmodule

// File: rtl/hvs_frame_shifter.sv
module hvs_frame_shifter import hvs_pkg::*; #(
   parameter int unsigned PAY_W        = 8,
   parameter int unsigned LEAD_W       = 1,
   parameter int unsigned TRAIL_W      = 2,
   parameter int unsigned RET_W        = 8,
   parameter int unsigned HALF_CYC     = 6,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned CLK_NS       = 20,
   parameter int unsigned MIN_PHASE_NS = 110,
   parameter int unsigned MIN_EDGE_NS  = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PAY_W-1:0] data_byte,
   input  logic [PAY_W-1:0] instr_byte,
   input  logic             ret_lane,
   output logic             ser_clk,
   output logic             dat_lane,
   output logic             ins_lane,
   output logic             busy,
   output logic             done,
   output logic [RET_W-1:0] rx_byte
);

   localparam int unsigned FRAME_W   = LEAD_W + PAY_W + TRAIL_W;
   localparam int unsigned BIT_W     = hvs_cnt_w(FRAME_W);
   localparam int unsigned NUM_LANES = 2;
   localparam int unsigned PHASE_NS  = HALF_CYC * CLK_NS;

   // elaboration-time parameter checks
   generate
      if (LEAD_W < 1 || TRAIL_W < 1) begin : g_bad_pad
         $error("frame padding widths must be at least one bit");
      end
      if (RET_W < 2 || RET_W > FRAME_W) begin : g_bad_ret
         $error("returned word must fit inside the frame");
      end
      if (HALF_CYC < 2 || HALF_CYC <= SYNC_STAGES) begin : g_bad_half
         $error("half period must exceed the return synchronizer depth");
      end
      if (PHASE_NS < MIN_PHASE_NS || PHASE_NS < MIN_EDGE_NS) begin : g_bad_time
         $error("half period too short for link timing");
      end
   endgenerate

   hvs_state_t       st;
   logic [BIT_W-1:0] bitn;
   logic             launch;
   logic             fall_tick;
   logic             last_fall;
   logic             take;
   logic             shift;
   logic [RET_W-1:0] cap;

   assign busy      = (st == ST_SHIFT);
   assign launch    = (st == ST_IDLE) && start;
   assign last_fall = fall_tick && (bitn == BIT_W'(FRAME_W - 1));
   assign take      = fall_tick && (bitn < BIT_W'(RET_W));
   assign shift     = fall_tick && !last_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         bitn    <= '0;
         done    <= 1'b0;
         rx_byte <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st   <= ST_SHIFT;
                  bitn <= '0;
               end
            end
            default: begin
               if (last_fall) begin
                  st      <= ST_IDLE;
                  done    <= 1'b1;
                  rx_byte <= cap;
               end else if (fall_tick) begin
                  bitn <= bitn + 1'b1;
               end
            end
         endcase
      end
   end

   hvs_phase_timer #(
      .HALF_CYC (HALF_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .ser_clk   (ser_clk),
      .fall_tick (fall_tick)
   );

   logic [NUM_LANES-1:0][PAY_W-1:0] lane_pay;
   logic [NUM_LANES-1:0]            lane_bit;

   assign lane_pay[0] = data_byte;
   assign lane_pay[1] = instr_byte;

   generate
      for (genvar g = 0; g < int'(NUM_LANES); g++) begin : g_lane
         hvs_lane_tx #(
            .PAY_W   (PAY_W),
            .LEAD_W  (LEAD_W),
            .TRAIL_W (TRAIL_W)
         ) u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (launch),
            .shift    (shift),
            .payload  (lane_pay[g]),
            .lane_out (lane_bit[g])
         );
      end
   endgenerate

   assign dat_lane = lane_bit[0];
   assign ins_lane = lane_bit[1];

   hvs_ret_capture #(
      .RET_W       (RET_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .ret_in (ret_lane),
      .clr    (launch),
      .take   (take),
      .word   (cap)
   );

   // R2: serial clock stays low outside a frame
   a_r2_idle_clock_low : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ser_clk);

   // R3, R4: both lanes rest low outside a frame
   a_r3_idle_lanes_low : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!dat_lane && !ins_lane));

   // R6: lanes move only while the serial clock is low
   a_r6_lanes_move_low : assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(dat_lane) || !$stable(ins_lane)) |-> !ser_clk);

   // R8: completion is a single-cycle pulse
   a_r8_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: busy ends exactly with done
   a_r9_busy_ends_done : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R10: a request during a frame does not end or restart it
   a_r10_start_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !last_fall) |=> (busy && !done));

endmodule

// File: tb/hvs_frame_shifter_test.sv
module hvs_frame_shifter_test;

   localparam int HALF   = 6;
   localparam int CLK_NS = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] data_byte = 8'h00;
   logic [7:0] instr_byte = 8'h00;
   logic       ret_lane = 1'b0;
   wire        ser_clk, dat_lane, ins_lane, busy, done;
   wire  [7:0] rx_byte;

   int compared = 0;
   int mismatched = 0;
   int rises = 0;

   always #10 clk = ~clk;

   always @(posedge ser_clk) rises++;

   hvs_frame_shifter #(.HALF_CYC(HALF), .CLK_NS(CLK_NS)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .data_byte(data_byte), .instr_byte(instr_byte), .ret_lane(ret_lane),
      .ser_clk(ser_clk), .dat_lane(dat_lane), .ins_lane(ins_lane),
      .busy(busy), .done(done), .rx_byte(rx_byte)
   );

   function automatic logic [10:0] framed(input logic [7:0] b);
      return {1'b0, b, 2'b00};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_frame(input logic [7:0] d, input logic [7:0] i,
                            input logic [7:0] r, input bit poke);
      logic [10:0] got_d = '0;
      logic [10:0] got_i = '0;
      logic        hd, hi;
      time         t_r, t_f;
      int          base;
      @(negedge clk);
      data_byte = d; instr_byte = i; start = 1'b1; base = rises;
      @(negedge clk);
      start = 1'b0;
      t_f = $time - 10;
      chk("R9", "busy after start", 32'(busy), 32'd1);
      for (int k = 0; k < 11; k++) begin
         @(posedge ser_clk);
         t_r = $time;
         chk("R5", "low phase ns", 32'(t_r - t_f), 32'(HALF * CLK_NS));
         hd = dat_lane; hi = ins_lane;
         got_d = {got_d[9:0], hd};
         got_i = {got_i[9:0], hi};
         #2;
         ret_lane = (k < 8) ? r[7-k] : 1'($urandom);
         for (int j = 0; j < HALF - 1; j++) begin
            @(negedge clk);
            if (poke && k == 4 && j == 0) begin
               start = 1'b1; data_byte = ~d; instr_byte = ~i;
            end
            if (poke && k == 4 && j == 1) start = 1'b0;
            chk("R6", "data lane held high", 32'(dat_lane), 32'(hd));
            chk("R6", "instr lane held high", 32'(ins_lane), 32'(hi));
         end
         @(negedge ser_clk);
         t_f = $time;
         chk("R5", "high phase ns", 32'(t_f - t_r), 32'(HALF * CLK_NS));
      end
      @(negedge clk);
      chk("R8", "done after last fall", 32'(done), 32'd1);
      chk("R9", "busy low with done", 32'(busy), 32'd0);
      chk("R7", "returned byte", 32'(rx_byte), 32'(r));
      chk("R3", "data lane frame", 32'(got_d), 32'(framed(d)));
      chk("R4", "instr lane frame", 32'(got_i), 32'(framed(i)));
      chk("R2", "rising edges", 32'(rises - base), 32'd11);
      chk("R2", "clock low at end", 32'(ser_clk), 32'd0);
      @(negedge clk);
      chk("R8", "done single cycle", 32'(done), 32'd0);
      chk("R8", "rx_byte held", 32'(rx_byte), 32'(r));
      if (poke) begin
         repeat (3 * HALF) @(negedge clk);
         chk("R10", "no chained frame edges", 32'(rises - base), 32'd11);
         chk("R10", "no chained frame busy", 32'(busy), 32'd0);
      end
   endtask

   initial begin
      void'($urandom(32'd915));
      repeat (3) @(negedge clk);
      chk("R1", "reset ser_clk", 32'(ser_clk), 32'd0);
      chk("R1", "reset lanes", 32'({dat_lane, ins_lane}), 32'd0);
      chk("R1", "reset busy/done", 32'({busy, done}), 32'd0);
      chk("R1", "reset rx_byte", 32'(rx_byte), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "after release", 32'({ser_clk, dat_lane, ins_lane, busy, done}), 32'd0);
      run_frame(8'h00, 8'h00, 8'h00, 1'b0);
      run_frame(8'hFF, 8'hFF, 8'hFF, 1'b0);
      run_frame(8'h80, 8'h01, 8'h81, 1'b0);
      run_frame(8'hA5, 8'h5A, 8'h3C, 1'b0);
      run_frame(8'h4C, 8'h2D, 8'hC3, 1'b1);
      for (int n = 0; n < 24; n++) begin
         run_frame(8'($urandom), 8'($urandom), 8'($urandom), 1'b0);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(CLK_NS * 150000);
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule